// File: doc/BRIEF.md
# Residue-Corrected Phase-Accumulator Clock Generator

This block makes an output clock of any frequency from a fixed reference clock. A wide accumulator adds a frequency word on every reference cycle. Each time the sum wraps, the output changes state. With a wrap alone, every output edge would fall on a reference edge, and the jitter would be one full reference period. To avoid this, the block reads the remainder left in the accumulator at the moment of the wrap. That remainder measures how far into the cycle the true edge fell.

The block quantises the top bits of the remainder into a multi-level DAC code. On the wrap cycle it drives this intermediate code for exactly one cycle. After that the code settles at the new full-scale level. A resistor DAC and an analog integrator outside this block turn the code stream into a waveform whose threshold crossing sits between reference edges. The peak residual jitter then falls to the reference period divided by the number of DAC levels. There is no feedback loop, so the generator is unconditionally stable.

The accumulator width `N` sets the frequency resolution. The code width `D` sets the number of DAC levels, with full scale FS = 2^D − 1. `D` must be at least 2.

Top module: `residue_clkgen`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator and the frequency register. It also forces `code_o` to 0, `level_o` low and `carry_o` low.
- R2: On each `clk` edge out of reset, the accumulator adds the registered frequency word modulo 2^N. `carry_o` is high for the one cycle after an edge at which the sum reached or passed 2^N. From reset with a constant word F held on `fcw_in`, the carry count over M cycles equals floor((M−1)·F / 2^N).
- R3: `fcw_in` is captured into a register at one edge and is first used in the addition at the following edge.
- R4: `level_o` inverts on every edge that produces a carry and holds otherwise.
- R5: On a carry edge, `code_o` takes an intermediate value. Let r be bits [N−1:N−D] of the wrapped sum, and let u = r clamped into the range 1 to FS−1. The code is u when the new level is high and FS−u when it is low.
- R6: On an edge without a carry, `code_o` becomes FS if `level_o` is high and 0 if it is low. An intermediate code therefore lasts one cycle unless another carry follows at once.
- R7: `code_o` never moves directly from 0 to FS, nor from FS to 0.
- R8: `code_o`, `level_o` and `carry_o` all update on the same edge that stores the wrapped sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw_in | input | N | Frequency control word |
| code_o | output | D | DAC code stream |
| level_o | output | 1 | Logic level of the generated clock |
| carry_o | output | 1 | One-cycle pulse for each accumulator wrap |

## Verification
The bench tries several frequency words:
- A fractional word near one sixth of the range, long enough for its carry count to be compared with the exact expected rate.
- Exactly half the range, where every remainder is zero and the code clamps to the bottom.
- The all-ones word, where every cycle wraps with a near-full remainder. This clamps the code to the top and keeps it from ever settling.
- A zero word, under which nothing may move.
- Irregular words swapped mid-run. These separate a design that uses the registered word from one that uses the input directly, and expose any off-by-one in the remainder bit selection.

Every cycle is compared with a bench-side model and screened for a direct jump between the two rails.

// File: rtl/residue_clkgen_pkg.sv
package residue_clkgen_pkg;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } level_e;

  // Clamp a residue slice into the open interval (0, fs) and orient it to the new level.
  function automatic int unsigned interp_code(input int unsigned resid_top,
                                              input int unsigned fs,
                                              input bit          rising);
    int unsigned u;
    u = resid_top;
    if (u < 1) u = 1;
    if (u > fs - 1) u = fs - 1;
    return rising ? u : (fs - u);
  endfunction

  // Settled rail value for a level.
  function automatic int unsigned rail_code(input bit high, input int unsigned fs);
    return high ? fs : 0;
  endfunction

endpackage

// File: rtl/residue_clkgen_fcw_reg.sv
module residue_clkgen_fcw_reg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fcw_in,
  output logic [N-1:0] fcw_q
);

  always_ff @(posedge clk) begin
    if (rst) fcw_q <= '0;
    else     fcw_q <= fcw_in;
  end

endmodule

// File: rtl/residue_clkgen_phase_acc.sv
module residue_clkgen_phase_acc #(
  parameter int N = 32,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fcw,
  output logic         wrap_w,
  output logic [D-1:0] resid_top_w,
  output logic         carry_q
);

  logic [N:0]   sum_w;
  logic [N-1:0] acc_q;

  assign sum_w       = {1'b0, acc_q} + {1'b0, fcw};
  assign wrap_w      = sum_w[N];
  assign resid_top_w = sum_w[N-1 -: D];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      acc_q   <= sum_w[N-1:0];
      carry_q <= sum_w[N];
    end
  end

  // R2: a carry pulse coincides with the stored phase moving backwards
  a_r2_carry_means_wrap: assert property (@(posedge clk) disable iff (rst)
    carry_q |-> (acc_q < $past(acc_q)));
  a_r2_no_carry_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !carry_q |-> (acc_q >= $past(acc_q)));

endmodule

// File: rtl/residue_clkgen_code_seq.sv
module residue_clkgen_code_seq
  import residue_clkgen_pkg::*;
#(
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wrap,
  input  logic [D-1:0] resid_top,
  output logic [D-1:0] code_q,
  output logic         level_q
);

  localparam int unsigned FS = (1 << D) - 1;
  localparam logic [D-1:0] FS_CODE = D'(FS);

  level_e lvl_q;
  logic   rising_w;

  assign rising_w = (lvl_q == LVL_LOW);
  assign level_q  = (lvl_q == LVL_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= LVL_LOW;
      code_q <= '0;
    end else if (wrap) begin
      lvl_q  <= rising_w ? LVL_HIGH : LVL_LOW;
      code_q <= D'(interp_code(int'(resid_top), FS, rising_w));
    end else begin
      code_q <= D'(rail_code(level_q, FS));
    end
  end

  // R4: level flips on a wrap, otherwise holds
  a_r4_level_flips: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (level_q != $past(level_q)));
  a_r4_level_holds: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(level_q));
  // R5: the wrap cycle leaves neither rail
  a_r5_mid_level: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (code_q != '0 && code_q != FS_CODE));
  // R6: without a wrap the code lands on the rail of the level
  a_r6_settle: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> (code_q == (level_q ? FS_CODE : '0)));
  // R7: no rail-to-rail step
  a_r7_no_rise_jump: assert property (@(posedge clk) disable iff (rst)
    (code_q == '0) |=> (code_q != FS_CODE));
  a_r7_no_fall_jump: assert property (@(posedge clk) disable iff (rst)
    (code_q == FS_CODE) |=> (code_q != '0));

endmodule

// File: rtl/residue_clkgen.sv
module residue_clkgen #(
  parameter int N = 32,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fcw_in,
  output logic [D-1:0] code_o,
  output logic         level_o,
  output logic         carry_o
);

  logic [N-1:0] fcw_q;
  logic         wrap_w;
  logic [D-1:0] resid_top_w;

  residue_clkgen_fcw_reg #(.N(N)) u_fcw (
    .clk    (clk),
    .rst    (rst),
    .fcw_in (fcw_in),
    .fcw_q  (fcw_q)
  );

  residue_clkgen_phase_acc #(.N(N), .D(D)) u_acc (
    .clk         (clk),
    .rst         (rst),
    .fcw         (fcw_q),
    .wrap_w      (wrap_w),
    .resid_top_w (resid_top_w),
    .carry_q     (carry_o)
  );

  residue_clkgen_code_seq #(.D(D)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .wrap      (wrap_w),
    .resid_top (resid_top_w),
    .code_q    (code_o),
    .level_q   (level_o)
  );

  // R8: the carry pulse and the level change share an edge
  a_r8_carry_with_level: assert property (@(posedge clk) disable iff (rst)
    carry_o |-> (level_o != $past(level_o)));
  // R1: held reset leaves all outputs idle
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (code_o == '0 && !level_o && !carry_o));

endmodule

// File: tb/residue_clkgen_test.sv
module residue_clkgen_test;

  localparam int N = 32;
  localparam int D = 4;
  localparam longint TWO_N = longint'(1) << N;
  localparam longint FS = (longint'(1) << D) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] fcw_in = '0;
  logic [D-1:0] code_o;
  logic         level_o;
  logic         carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  residue_clkgen #(.N(N), .D(D)) uut (
    .clk(clk), .rst(rst), .fcw_in(fcw_in),
    .code_o(code_o), .level_o(level_o), .carry_o(carry_o)
  );

  always #5 clk = ~clk;

  // bench-side expectation, restated from the requirements
  longint m_acc, m_fcw, m_code;
  bit     m_lvl, m_carry;
  longint prev_code;

  always @(posedge clk) begin
    longint s, r, u;
    if (rst) begin
      m_acc = 0; m_fcw = 0; m_lvl = 0; m_code = 0; m_carry = 0;
    end else begin
      s = m_acc + m_fcw;
      m_carry = (s >= TWO_N);
      if (m_carry) s = s - TWO_N;
      m_acc = s;
      m_fcw = longint'(fcw_in);
      if (m_carry) begin
        m_lvl = !m_lvl;
        r = s >> (N - D);
        u = (r == 0) ? 1 : ((r == FS) ? FS - 1 : r);
        m_code = m_lvl ? u : FS - u;
      end else begin
        m_code = m_lvl ? FS : 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [N-1:0] f);
    @(negedge clk);
    rst = 1'b1;
    fcw_in = f;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    prev_code = 0;
  endtask

  // compare every output with the model for n cycles; R7 screen on code
  task automatic run_cmp(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(carry_o == m_carry, "R2 carry", carry_o, m_carry);
      chk(level_o == m_lvl, "R4 level", level_o, m_lvl);
      chk(longint'(code_o) == m_code, m_carry ? "R5 mid code" : "R6 rail code",
          code_o, m_code);
      chk(!((prev_code == 0 && code_o == FS) || (prev_code == FS && code_o == 0)),
          "R7 rail jump", code_o, prev_code);
      prev_code = code_o;
    end
  endtask

  task automatic t_reset;
    do_reset(32'h1234_5678);
    rst = 1'b1;
    @(negedge clk);
    chk(code_o == 0, "R1 code", code_o, 0);
    chk(level_o == 0, "R1 level", level_o, 0);
    chk(carry_o == 0, "R1 carry", carry_o, 0);
    rst = 1'b0;
  endtask

  task automatic t_rate;
    longint f, cnt, exp;
    int m;
    f = 64'h2AAA_AAAB;
    m = 3000;
    cnt = 0;
    do_reset(N'(f));
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      cnt += carry_o;
      chk(longint'(code_o) == m_code, "R5 R6 code in rate run", code_o, m_code);
    end
    exp = (longint'(m - 1) * f) >> N;
    chk(cnt == exp, "R2 carry count", cnt, exp);
  endtask

  task automatic t_latency;
    do_reset('0);
    @(negedge clk);
    fcw_in = 32'h8000_0000;
    @(negedge clk);   // word captured, added nothing yet
    chk(carry_o == 0, "R3 first edge", carry_o, 0);
    @(negedge clk);   // phase now half
    chk(carry_o == 0, "R3 second edge", carry_o, 0);
    @(negedge clk);   // phase wraps
    chk(carry_o == 1, "R3 R8 wrap edge", carry_o, 1);
    chk(level_o == 1, "R8 level with carry", level_o, 1);
    chk(code_o == 1, "R5 zero residue rising", code_o, 1);
    @(negedge clk);
    chk(code_o == FS, "R6 settles high", code_o, FS);
  endtask

  task automatic t_half;
    do_reset(32'h8000_0000);
    prev_code = 0;
    run_cmp(40);
    chk(code_o == FS || code_o == 0 || code_o == 1 || code_o == FS - 1,
        "R5 clamp low boundary", code_o, 1);
  endtask

  task automatic t_max;
    do_reset(32'hFFFF_FFFF);
    run_cmp(3);
    // from here every cycle wraps with a near-full residue
    @(negedge clk);
    chk(carry_o == 1, "R2 continuous carry", carry_o, 1);
    chk(code_o == FS - 1 || code_o == 1, "R5 clamp high boundary", code_o, FS - 1);
    prev_code = code_o;
    run_cmp(20);
  endtask

  task automatic t_zero;
    do_reset('0);
    run_cmp(30);
    chk(level_o == 0 && code_o == 0, "R2 zero word idle", code_o, 0);
  endtask

  task automatic t_sweep;
    do_reset(32'h1000_0001);
    run_cmp(60);
    @(negedge clk);
    fcw_in = 32'h7654_3210;
    prev_code = code_o;
    run_cmp(60);
    fcw_in = 32'h0123_4567;
    run_cmp(300);
    fcw_in = 32'hC000_0003;
    run_cmp(60);
  endtask

  initial begin
    t_reset;
    t_latency;
    t_rate;
    t_half;
    t_max;
    t_zero;
    t_sweep;
    t_reset;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule